// File: doc/BRIEF.md
# UART Receive FIFO with Burst Drain

This block sits on the receive side of a 16550-style UART, after the deserializer. It stores each received character together with its parity and framing flags in a FIFO. A host on a simple memory-mapped register bus drains the FIFO in one of two ways. A byte read takes one character per access. A 32-bit burst read takes up to four characters in one access. A packed status word gives the host everything it needs to plan a drain in a single read: the fill level, an interrupt-pending flag and the receive line-status bits.

The intended host loop reads the status word first. While four or more characters are held, it issues burst reads. It finishes the last zero to three characters with byte reads. A control byte lets the host flush the FIFO, clear a latched overrun and choose the fill level at which the interrupt output fires.

The storage is four interleaved banks with one read port each, so a block-RAM style memory can serve a four-character read in a single cycle. Read data is returned one clock after the read strobe.

Top module: `uart_rx_burst_reader`

## Requirements
- R1: After reset the FIFO is empty, `irq` is low and the status word reads 0x0010_0000.
- R2: A read at word address 0 (byte offset 0x00) removes the oldest character and returns it in bits [7:0] with zeros above. On an empty FIFO it returns zero and changes nothing.
- R3: A read at byte offset 0xA4 with four or more characters held removes four characters. The oldest is returned in bits [7:0] and the newer ones in the higher byte lanes, in arrival order.
- R4: A burst read with n < 4 characters held returns those n characters in the low lanes and zeros in the other lanes. It removes only those n characters.
- R5: The status word at byte offset 0x9C holds the number of stored characters in bits [7:0]. Bit 24 is set when that number is nonzero. Bits [19:8], [23:21] and [30:28] read zero.
- R6: Status bit 26 shows the parity flag and bit 27 the framing flag of the character at the FIFO head, and both are zero when the FIFO is empty. Bit 31 is set while any stored character carries either flag.
- R7: The FIFO holds 2**ADDR_W-1 characters. A character that arrives while the FIFO is full is dropped and sets the overrun flag (status bit 25). Overrun stays set until the host clears it with a control write.
- R8: A write to word address 0 with byte enable 2 set loads the control byte from write-data bits [23:16]. Bit 1 of that byte flushes the FIFO and clears overrun. Bits [7:6] select the trigger level: code 0, 1, 2 and 3 give 1, 4, 8 and 14 characters. The value 0x43 therefore flushes, clears overrun and selects level 4.
- R9: `irq` is high when the stored count is at or above the trigger level, when overrun is set, or when any stored character carries an error flag. Status bit 20 reads as the inverse of `irq`.
- R10: `bus_rvalid` and `bus_rdata` respond in the clock after a read strobe. A status read removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| bus_addr | input | 8 | Byte address; bits [7:2] select the word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Write byte enables |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Receive interrupt request |

## Verification
The FIFO is filled to every level from empty to full under each of the four trigger codes. This separates an off-by-one trigger compare from a correct one and shows exactly where the overrun drop happens. Drains use burst reads of distinct byte values followed by byte reads, which exposes any lane-order or bank-rotation fault. Burst reads with zero to three characters held show that unused lanes are zeroed and that only the valid characters are removed. Sequences of characters with mixed parity and framing flags, drained one byte at a time, tell head-only flag reporting apart from the any-stored error bit.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  localparam int LANES = 4;
  localparam logic [5:0] WA_DATA   = 6'h00;  // byte 0x00: byte pop, ctrl in lane 2
  localparam logic [5:0] WA_STATUS = 6'h27;  // byte 0x9C
  localparam logic [5:0] WA_BURST  = 6'h29;  // byte 0xA4

  typedef enum logic [1:0] {RS_NONE, RS_DATA, RS_STATUS} rsel_e;

  function automatic logic [7:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd14;
    endcase
  endfunction
endpackage

// File: rtl/ubr_bank_ram.sv
module ubr_bank_ram #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ubr_fifo.sv
module ubr_fifo #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [7:0]        push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              pop,
  input  logic              pop_burst,
  output logic [ADDR_W-1:0] count,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              err_any,
  output logic              dropped,
  output logic [31:0]       rd_word
);
  localparam int SLOTS = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - 2;
  localparam int LANES = ubr_pkg::LANES;

  logic [ADDR_W-1:0] head, tail, err_cnt;
  logic [SLOTS-1:0]  perr_v, ferr_v;
  logic              full, push_ok;
  logic [2:0]        pop_n, pop_err, n_q;
  logic [1:0]        hlo_q;
  logic [7:0]        bank_q [LANES];

  assign full    = (count == ADDR_W'(SLOTS - 1));
  assign push_ok = push & ~full;
  assign dropped = push & full;

  always_comb begin
    if (!pop)                      pop_n = 3'd0;
    else if (!pop_burst)           pop_n = (count != '0) ? 3'd1 : 3'd0;
    else if (count >= ADDR_W'(4))  pop_n = 3'd4;
    else                           pop_n = count[2:0];
  end

  always_comb begin
    pop_err = 3'd0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < pop_n)
        pop_err = pop_err + 3'(perr_v[head + ADDR_W'(i)] | ferr_v[head + ADDR_W'(i)]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) tail <= tail + ADDR_W'(1);
      head    <= head + ADDR_W'(pop_n);
      count   <= count + ADDR_W'(push_ok) - ADDR_W'(pop_n);
      err_cnt <= err_cnt + ADDR_W'(push_ok & (push_perr | push_ferr)) - ADDR_W'(pop_err);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_v <= '0;
      ferr_v <= '0;
    end else if (push_ok) begin
      perr_v[tail] <= push_perr;
      ferr_v[tail] <= push_ferr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= 3'd0;
      hlo_q <= 2'd0;
    end else begin
      n_q   <= pop_n;
      hlo_q <= head[1:0];
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0]        ln;
    logic [ADDR_W-1:0] idx;
    assign ln  = 2'(b) - head[1:0];
    assign idx = head + ADDR_W'(ln);
    ubr_bank_ram #(.ROW_W(ROW_W), .DATA_W(8)) u_bank (
      .clk   (clk),
      .we    (push_ok && (tail[1:0] == 2'(b))),
      .waddr (tail[ADDR_W-1:2]),
      .wdata (push_data),
      .re    (pop),
      .raddr (idx[ADDR_W-1:2]),
      .rdata (bank_q[b])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] src;
    assign src = hlo_q + 2'(i);
    assign rd_word[8*i +: 8] = (3'(i) < n_q) ? bank_q[src] : 8'h00;
  end

  assign head_perr = perr_v[head];
  assign head_ferr = ferr_v[head];
  assign err_any   = (err_cnt != '0);

  // R4: a pop from an empty FIFO yields all-zero lanes
  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> (rd_word == 32'h0));
  // R3: a burst pop with four or more held lowers the count by four
  a_r3_burst_takes_four: assert property (@(posedge clk) disable iff (rst)
    (pop && pop_burst && count >= ADDR_W'(4) && !push && !flush)
      |=> (count == $past(count) - ADDR_W'(4)));
  // R7: a full FIFO does not grow on an arrival
  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/uart_rx_burst_reader.sv
module uart_rx_burst_reader #(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic [7:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq
);
  import ubr_pkg::*;

  logic [5:0]        wa;
  logic              rd_byte, rd_burst, rd_stat, ctrl_wr, flush;
  logic [7:0]        ctrl_b, count8;
  logic [1:0]        trig_code;
  logic              ovr;
  logic [ADDR_W-1:0] count;
  logic              head_perr, head_ferr, err_any, dropped, nonempty;
  logic [31:0]       rd_word, stat_w, stat_q;
  rsel_e             rsel_q;

  assign wa       = bus_addr[7:2];
  assign rd_byte  = bus_rd && (wa == WA_DATA);
  assign rd_burst = bus_rd && (wa == WA_BURST);
  assign rd_stat  = bus_rd && (wa == WA_STATUS);
  assign ctrl_wr  = bus_wr && (wa == WA_DATA) && bus_be[2];
  assign ctrl_b   = bus_wdata[23:16];
  assign flush    = ctrl_wr && ctrl_b[1];

  ubr_fifo #(.ADDR_W(ADDR_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (rx_valid),
    .push_data (rx_data),
    .push_perr (rx_perr),
    .push_ferr (rx_ferr),
    .pop       (rd_byte || rd_burst),
    .pop_burst (rd_burst),
    .count     (count),
    .head_perr (head_perr),
    .head_ferr (head_ferr),
    .err_any   (err_any),
    .dropped   (dropped),
    .rd_word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)          trig_code <= 2'd0;
    else if (ctrl_wr) trig_code <= ctrl_b[7:6];
  end

  always_ff @(posedge clk) begin
    if (rst)          ovr <= 1'b0;
    else if (dropped) ovr <= 1'b1;
    else if (flush)   ovr <= 1'b0;
  end

  assign count8   = 8'(count);
  assign nonempty = (count != '0);
  assign irq      = (count8 >= trig_level(trig_code)) || ovr || err_any;

  always_comb begin
    stat_w        = 32'h0;
    stat_w[7:0]   = count8;
    stat_w[20]    = ~irq;
    stat_w[24]    = nonempty;
    stat_w[25]    = ovr;
    stat_w[26]    = nonempty & head_perr;
    stat_w[27]    = nonempty & head_ferr;
    stat_w[31]    = err_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q     <= RS_NONE;
      stat_q     <= 32'h0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (rd_stat) stat_q <= stat_w;
      if (rd_byte || rd_burst) rsel_q <= RS_DATA;
      else if (rd_stat)        rsel_q <= RS_STATUS;
      else                     rsel_q <= RS_NONE;
    end
  end

  always_comb begin
    case (rsel_q)
      RS_DATA:   bus_rdata = rd_word;
      RS_STATUS: bus_rdata = stat_q;
      default:   bus_rdata = 32'h0;
    endcase
  end

  // R7: a dropped arrival leaves overrun set
  a_r7_drop_sets_ovr: assert property (@(posedge clk) disable iff (rst)
    dropped |=> ovr);
  // R7: overrun holds until a flushing control write
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && !flush) |=> ovr);
  // R8: a flushing control write empties the FIFO
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
  // R9: pending bit of a status read is the inverse of irq at the read
  a_r9_pending_inverse: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (bus_rdata[20] == !$past(irq)));
  // R5: data-ready bit of a status read matches occupancy at the read
  a_r5_ready_bit: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (bus_rdata[24] == ($past(count) != '0)));
  // R10: every read strobe is answered in the next cycle
  a_r10_rvalid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/sim_uart_rx_burst_reader.sv
module sim_uart_rx_burst_reader;
  localparam int AW  = 4;
  localparam int CAP = (1 << AW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [7:0]  rx_data = 8'h0, bus_addr = 8'h0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic [3:0]  bus_be = 4'h0;
  logic        bus_rvalid, irq;

  int checks = 0;
  int errors = 0;

  logic [9:0]  mq[$];        // {ferr, perr, data}
  logic        ovr_m = 1'b0;
  logic [1:0]  tc_m  = 2'd0;

  always #5 clk = ~clk;

  uart_rx_burst_reader #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic any_err();
    foreach (mq[i]) if (mq[i][9] || mq[i][8]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_irq();
    return (mq.size() >= lvl(tc_m)) || ovr_m || any_err();
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'h0;
    s[7:0] = 8'(mq.size());
    s[20]  = !exp_irq();
    s[24]  = (mq.size() != 0);
    s[25]  = ovr_m;
    if (mq.size() != 0) begin
      s[26] = mq[0][8];
      s[27] = mq[0][9];
    end
    s[31]  = any_err();
    return s;
  endfunction

  task automatic push_ch(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    if (mq.size() < CAP) mq.push_back({fe, pe, d});
    else ovr_m = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 rvalid", 32'(bus_rvalid), 32'h1);
    d = bus_rdata;
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_be = 4'b0100; bus_wdata = {8'h0, v, 16'h0};
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
    tc_m = v[7:6];
    if (v[1]) begin mq.delete(); ovr_m = 1'b0; end
  endtask

  task automatic check_status(input string req);
    logic [31:0] d;
    bus_read(8'h9C, d);
    chk(req, d, exp_status());
    chk({req, " irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic read_byte();
    logic [31:0] d, e;
    e = (mq.size() != 0) ? {24'h0, mq[0][7:0]} : 32'h0;
    bus_read(8'h00, d);
    if (mq.size() != 0) void'(mq.pop_front());
    chk("R2 byte read", d, e);
  endtask

  task automatic read_burst(input string req);
    logic [31:0] d, e;
    int n;
    e = 32'h0;
    n = (mq.size() < 4) ? mq.size() : 4;
    for (int i = 0; i < n; i++) e[8*i +: 8] = mq[i][7:0];
    bus_read(8'hA4, d);
    for (int i = 0; i < n; i++) void'(mq.pop_front());
    chk(req, d, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s1, s2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    check_status("R1 status");
    chk("R1 status value", exp_status(), 32'h0010_0000);
    // R2 empty byte read
    read_byte();
    check_status("R2 empty unchanged");

    // R8/R9/R7/R3 sweep over all trigger codes and fill levels
    for (int tc = 0; tc < 4; tc++) begin
      ctrl_write(8'((tc << 6) | 2));
      check_status("R8 flush");
      for (int f = 1; f <= CAP; f++) begin
        push_ch(8'(f * 7 + tc * 50), 1'b0, 1'b0);
        chk("R9 irq level", 32'(irq), 32'(exp_irq()));
        check_status("R5 count");
      end
      push_ch(8'hEE, 1'b0, 1'b0);
      check_status("R7 overrun");
      while (mq.size() >= 4) read_burst("R3 burst");
      while (mq.size() != 0) read_byte();
      check_status("R7 overrun sticky");
    end
    ctrl_write(8'h43);
    check_status("R8 clear 0x43");

    // R4 short bursts
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < k; j++) push_ch(8'(8'hA0 + k * 16 + j), 1'b0, 1'b0);
      read_burst("R4 short burst");
      check_status("R4 after short");
    end
    for (int j = 0; j < 6; j++) push_ch(8'(8'h30 + j), 1'b0, 1'b0);
    read_burst("R3 burst of six");
    read_burst("R4 tail of six");
    check_status("R4 empty after");

    // R6 error flags, head-only vs any stored
    push_ch(8'h11, 1'b0, 1'b0);
    push_ch(8'h22, 1'b1, 1'b0);
    push_ch(8'h33, 1'b0, 1'b1);
    push_ch(8'h44, 1'b0, 1'b0);
    push_ch(8'h55, 1'b1, 1'b1);
    push_ch(8'h66, 1'b0, 1'b0);
    check_status("R6 flags");
    while (mq.size() != 0) begin
      read_byte();
      check_status("R6 flags");
    end
    push_ch(8'h77, 1'b1, 1'b0);
    push_ch(8'h78, 1'b0, 1'b0);
    push_ch(8'h79, 1'b0, 1'b1);
    push_ch(8'h7A, 1'b0, 1'b0);
    push_ch(8'h7B, 1'b0, 1'b0);
    read_burst("R6 burst over errors");
    check_status("R6 after burst");
    read_byte();
    check_status("R6 drained");

    // R10 status read removes nothing
    for (int j = 0; j < 3; j++) push_ch(8'(8'hC0 + j), 1'b0, 1'b0);
    bus_read(8'h9C, s1);
    bus_read(8'h9C, s2);
    chk("R10 status no pop", s2, s1);
    chk("R10 status value", s2, exp_status());
    read_burst("R10 data intact");

    // R8 flush with content, no overrun
    for (int j = 0; j < 5; j++) push_ch(8'(8'hD0 + j), 1'b0, 1'b0);
    ctrl_write(8'h42);
    check_status("R8 flush content");
    read_byte();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule